// File: doc/BRIEF.md
# Light-Load Mode Controller

This block chooses, for a single buck regulator channel, between fixed-frequency pulse-width operation and pulse-frequency operation at light load. It watches the digitized inductor current that arrives once per switching cycle. When that current has stayed under a programmable threshold for a programmable run of consecutive cycles, it moves the channel into pulse-frequency mode. It then turns off the pulse-width loop and freezes the duty value that the loop last produced, so that pulses start with the same ripple as before.

While in pulse-frequency mode, the controller asks the modulator for one pulse each time the scaled output drops below the reference. It waits for each pulse to finish before it accepts another request. It also measures the idle gap, called the dead zone, between the end of one pulse and the next request. When the output leaves the regulation window on either side, the channel goes back to pulse-width operation. A mode-enable input can hold the channel in pulse-width operation at any time.

Top module: `lload_mode_ctrl`

## Requirements
- R1: A current sample counts as low when `i_sample < cfg_i_thresh` (unsigned). With `cfg_entry_cycles` = N > 0, `mode_pfm` rises at the clock edge that samples the Nth consecutive `cyc_strobe` carrying a low sample.
- R2: A `cfg_entry_cycles` value of 0 selects the default entry run of 20 consecutive low strobes.
- R3: A strobe whose sample is at or above the threshold (equality included) restarts the run from zero. Clocks without a strobe neither advance nor clear the run.
- R4: `pwm_loop_off` is high exactly while `mode_pfm` is high.
- R5: In pulse-frequency mode with no pulse outstanding, a clock edge that samples `cmp_below_ref` high produces a one-cycle `pfm_trigger` after that edge. `pfm_trigger` is never high in pulse-width mode.
- R6: After a trigger, no further trigger is issued until an edge has sampled `pulse_done` high. At most one pulse is outstanding.
- R7: In pulse-frequency mode, an edge that samples `cmp_above_hi` or `cmp_below_lo` high returns the channel to pulse-width mode at that edge, with no trigger. Re-entry then needs a fresh full run.
- R8: While `cfg_mode_en` is low, the channel is forced to pulse-width mode from the next edge on, the run is cleared, and strobes have no effect.
- R9: `pfm_duty` captures `pwm_duty` at the entry edge and holds that value for the whole stay in pulse-frequency mode.
- R10: `dz_last` reports, at each trigger, the number of idle clock edges between the edge that sampled `pulse_done` (or the entry edge) and the triggering edge. The count saturates at 2^TW-1 and is held between triggers.
- R11: After reset, `mode_pfm`, `pwm_loop_off`, `pfm_trigger`, `pfm_duty` and `dz_last` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode_en | input | 1 | Allows pulse-frequency mode when high |
| cfg_i_thresh | input | IW | Light-load current threshold |
| cfg_entry_cycles | input | CW | Consecutive low cycles needed for entry (0 = default 20) |
| cyc_strobe | input | 1 | One-clock marker of a new switching-cycle current sample |
| i_sample | input | IW | Digitized inductor current for this cycle |
| cmp_below_ref | input | 1 | Scaled output below the reference |
| cmp_above_hi | input | 1 | Scaled output above the upper window limit |
| cmp_below_lo | input | 1 | Scaled output below the lower window limit |
| pwm_duty | input | DW | Current duty value from the pulse-width loop |
| pulse_done | input | 1 | Modulator reports the requested pulse has completed |
| mode_pfm | output | 1 | 1 = pulse-frequency mode, 0 = pulse-width mode |
| pwm_loop_off | output | 1 | Disables the pulse-width regulation loop |
| pfm_trigger | output | 1 | One-cycle request for a single pulse |
| pfm_duty | output | DW | Duty value to use for pulse-frequency pulses |
| dz_last | output | TW | Last measured dead-zone length in clocks |

## Verification
The bound checker checks the following on every cycle. Mode follows the loop-disable output. Triggers occur only in pulse-frequency mode, only after a below-reference sample, and never on two edges in a row. A window violation or a low enable forces pulse-width mode at the next edge. Entry happens only on a strobe that carries a low sample, and the frozen duty stays stable throughout pulse-frequency mode. The bench's scenarios are the only place where the exact length of the entry run is shown. The same holds for how an equal-to-threshold sample and the zero-means-default setting affect that run, the one-outstanding-pulse trigger count, and the measured and saturated dead-zone values, which a cycle-level reference model confirms.

// File: rtl/lload_pkg.sv
package lload_pkg;
   typedef enum logic {
      MODE_PWM = 1'b0,
      MODE_PFM = 1'b1
   } lload_mode_e;

   typedef enum logic {
      DZ_WRAP     = 1'b0,
      DZ_SATURATE = 1'b1
   } dz_policy_e;
endpackage

// File: rtl/lload_entry_cnt.sv
module lload_entry_cnt #(
   parameter int IW        = 10,
   parameter int CW        = 8,
   parameter int DEF_ENTRY = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          count_en,
   input  logic          cyc_strobe,
   input  logic [IW-1:0] i_sample,
   input  logic [IW-1:0] i_thresh,
   input  logic [CW-1:0] cfg_cycles,
   output logic          enter_req
);
   localparam logic [CW:0] DEF_NEED = (CW + 1)'(DEF_ENTRY);

   logic [CW-1:0] run_q;
   logic [CW:0]   need;
   logic [CW:0]   run_next;
   logic          is_low;
   logic          reached;

   always_comb begin
      need     = (cfg_cycles == '0) ? DEF_NEED : {1'b0, cfg_cycles};
      run_next = {1'b0, run_q} + (CW + 1)'(1);
      is_low   = (i_sample < i_thresh);
      reached  = (run_next >= need);
      enter_req = count_en && cyc_strobe && is_low && reached;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (!count_en) begin
         run_q <= '0;
      end else if (cyc_strobe) begin
         if (!is_low || reached) begin
            run_q <= '0;
         end else begin
            run_q <= run_next[CW-1:0];
         end
      end
   end
endmodule

// File: rtl/lload_mode_fsm.sv
module lload_mode_fsm
   import lload_pkg::*;
#(
   parameter int DW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_en,
   input  logic          enter_req,
   input  logic          window_exit,
   input  logic [DW-1:0] pwm_duty,
   output logic          mode_pfm,
   output logic          loop_off,
   output logic [DW-1:0] pfm_duty
);
   lload_mode_e   mode_q, mode_d;
   logic [DW-1:0] duty_q;

   always_comb begin
      mode_d = mode_q;
      if (!mode_en) begin
         mode_d = MODE_PWM;
      end else begin
         unique case (mode_q)
            MODE_PWM: if (enter_req)   mode_d = MODE_PFM;
            MODE_PFM: if (window_exit) mode_d = MODE_PWM;
            default:                   mode_d = MODE_PWM;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_PWM;
         duty_q <= '0;
      end else begin
         mode_q <= mode_d;
         if (mode_q == MODE_PWM && mode_d == MODE_PFM) begin
            duty_q <= pwm_duty;
         end
      end
   end

   assign mode_pfm = (mode_q == MODE_PFM);
   assign loop_off = (mode_q == MODE_PFM);
   assign pfm_duty = duty_q;
endmodule

// File: rtl/lload_pulse_seq.sv
module lload_pulse_seq
   import lload_pkg::*;
#(
   parameter int         TW        = 8,
   parameter dz_policy_e DZ_POLICY = DZ_SATURATE
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic          below_ref,
   input  logic          pulse_done,
   output logic          trigger,
   output logic [TW-1:0] dz_last
);
   localparam logic [TW-1:0] DZ_MAX = '1;

   logic          busy_q;
   logic          trig_q;
   logic [TW-1:0] dz_run_q;
   logic [TW-1:0] dz_last_q;
   logic [TW-1:0] dz_inc;

   generate
      if (DZ_POLICY == DZ_SATURATE) begin : g_dz_sat
         assign dz_inc = (dz_run_q == DZ_MAX) ? DZ_MAX : dz_run_q + TW'(1);
      end else begin : g_dz_wrap
         assign dz_inc = dz_run_q + TW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         trig_q    <= 1'b0;
         dz_run_q  <= '0;
         dz_last_q <= '0;
      end else if (!active) begin
         busy_q   <= 1'b0;
         trig_q   <= 1'b0;
         dz_run_q <= '0;
      end else begin
         trig_q <= 1'b0;
         if (busy_q) begin
            if (pulse_done) begin
               busy_q   <= 1'b0;
               dz_run_q <= '0;
            end
         end else if (below_ref) begin
            trig_q    <= 1'b1;
            busy_q    <= 1'b1;
            dz_last_q <= dz_run_q;
            dz_run_q  <= '0;
         end else begin
            dz_run_q <= dz_inc;
         end
      end
   end

   assign trigger = trig_q;
   assign dz_last = dz_last_q;
endmodule

// File: rtl/lload_mode_ctrl.sv
module lload_mode_ctrl
   import lload_pkg::*;
#(
   parameter int         IW        = 10,
   parameter int         CW        = 8,
   parameter int         DW        = 12,
   parameter int         TW        = 8,
   parameter int         DEF_ENTRY = 20,
   parameter dz_policy_e DZ_POLICY = DZ_SATURATE
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_mode_en,
   input  logic [IW-1:0] cfg_i_thresh,
   input  logic [CW-1:0] cfg_entry_cycles,
   input  logic          cyc_strobe,
   input  logic [IW-1:0] i_sample,
   input  logic          cmp_below_ref,
   input  logic          cmp_above_hi,
   input  logic          cmp_below_lo,
   input  logic [DW-1:0] pwm_duty,
   input  logic          pulse_done,
   output logic          mode_pfm,
   output logic          pwm_loop_off,
   output logic          pfm_trigger,
   output logic [DW-1:0] pfm_duty,
   output logic [TW-1:0] dz_last
);
   generate
      if (IW < 1) begin : g_bad_iw
         $error("lload_mode_ctrl: IW must be at least 1");
      end
      if (CW < 2) begin : g_bad_cw
         $error("lload_mode_ctrl: CW must be at least 2");
      end
      if (DW < 1) begin : g_bad_dw
         $error("lload_mode_ctrl: DW must be at least 1");
      end
      if (TW < 2) begin : g_bad_tw
         $error("lload_mode_ctrl: TW must be at least 2");
      end
      if (DEF_ENTRY < 1 || DEF_ENTRY >= (1 << CW)) begin : g_bad_def
         $error("lload_mode_ctrl: DEF_ENTRY must fit in CW bits and be nonzero");
      end
   endgenerate

   logic enter_req;
   logic window_exit;
   logic count_en;
   logic seq_active;

   assign window_exit = cmp_above_hi | cmp_below_lo;
   assign count_en    = cfg_mode_en & ~mode_pfm;
   assign seq_active  = cfg_mode_en & mode_pfm & ~window_exit;

   lload_entry_cnt #(
      .IW        (IW),
      .CW        (CW),
      .DEF_ENTRY (DEF_ENTRY)
   ) entry_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .count_en   (count_en),
      .cyc_strobe (cyc_strobe),
      .i_sample   (i_sample),
      .i_thresh   (cfg_i_thresh),
      .cfg_cycles (cfg_entry_cycles),
      .enter_req  (enter_req)
   );

   lload_mode_fsm #(
      .DW (DW)
   ) fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_en     (cfg_mode_en),
      .enter_req   (enter_req),
      .window_exit (window_exit),
      .pwm_duty    (pwm_duty),
      .mode_pfm    (mode_pfm),
      .loop_off    (pwm_loop_off),
      .pfm_duty    (pfm_duty)
   );

   lload_pulse_seq #(
      .TW        (TW),
      .DZ_POLICY (DZ_POLICY)
   ) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (seq_active),
      .below_ref  (cmp_below_ref),
      .pulse_done (pulse_done),
      .trigger    (pfm_trigger),
      .dz_last    (dz_last)
   );
endmodule

// File: rtl/lload_mode_ctrl_chk.sv
module lload_mode_ctrl_chk #(
   parameter int IW = 10,
   parameter int CW = 8,
   parameter int DW = 12,
   parameter int TW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_mode_en,
   input logic [IW-1:0] cfg_i_thresh,
   input logic          cyc_strobe,
   input logic [IW-1:0] i_sample,
   input logic          cmp_below_ref,
   input logic          cmp_above_hi,
   input logic          cmp_below_lo,
   input logic          mode_pfm,
   input logic          pwm_loop_off,
   input logic          pfm_trigger,
   input logic [DW-1:0] pfm_duty
);
   a_r1_entry_on_low_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_pfm) |-> ($past(cyc_strobe) && $past(i_sample < cfg_i_thresh)));

   a_r4_loop_off_matches_mode: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_loop_off == mode_pfm);

   a_r5_trigger_only_in_pfm: assert property (@(posedge clk) disable iff (!rst_n)
      pfm_trigger |-> (mode_pfm && $past(cmp_below_ref)));

   a_r6_no_back_to_back_trigger: assert property (@(posedge clk) disable iff (!rst_n)
      pfm_trigger |=> !pfm_trigger);

   a_r7_window_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_pfm && (cmp_above_hi || cmp_below_lo)) |=> (!mode_pfm && !pfm_trigger));

   a_r8_disable_forces_pwm: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_mode_en |=> (!mode_pfm && !pfm_trigger));

   a_r9_duty_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_pfm && $past(mode_pfm)) |-> $stable(pfm_duty));
endmodule

bind lload_mode_ctrl lload_mode_ctrl_chk #(
   .IW (IW),
   .CW (CW),
   .DW (DW),
   .TW (TW)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_mode_en   (cfg_mode_en),
   .cfg_i_thresh  (cfg_i_thresh),
   .cyc_strobe    (cyc_strobe),
   .i_sample      (i_sample),
   .cmp_below_ref (cmp_below_ref),
   .cmp_above_hi  (cmp_above_hi),
   .cmp_below_lo  (cmp_below_lo),
   .mode_pfm      (mode_pfm),
   .pwm_loop_off  (pwm_loop_off),
   .pfm_trigger   (pfm_trigger),
   .pfm_duty      (pfm_duty)
);

// File: tb/lload_mode_ctrl_tb_top.sv
module lload_mode_ctrl_tb_top;
   localparam int IW = 10;
   localparam int CW = 8;
   localparam int DW = 12;
   localparam int TW = 8;
   localparam int DZ_MAX = (1 << TW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_mode_en = 1'b0;
   logic [IW-1:0] cfg_i_thresh = '0;
   logic [CW-1:0] cfg_entry_cycles = '0;
   logic          cyc_strobe = 1'b0;
   logic [IW-1:0] i_sample = '0;
   logic          cmp_below_ref = 1'b0;
   logic          cmp_above_hi = 1'b0;
   logic          cmp_below_lo = 1'b0;
   logic [DW-1:0] pwm_duty = '0;
   logic          pulse_done = 1'b0;
   logic          mode_pfm;
   logic          pwm_loop_off;
   logic          pfm_trigger;
   logic [DW-1:0] pfm_duty;
   logic [TW-1:0] dz_last;

   int n_tests = 0;
   int n_fail  = 0;
   bit done_flag = 1'b0;

   always #5 clk = ~clk;

   lload_mode_ctrl dut_i (
      .clk              (clk),
      .rst_n            (rst_n),
      .cfg_mode_en      (cfg_mode_en),
      .cfg_i_thresh     (cfg_i_thresh),
      .cfg_entry_cycles (cfg_entry_cycles),
      .cyc_strobe       (cyc_strobe),
      .i_sample         (i_sample),
      .cmp_below_ref    (cmp_below_ref),
      .cmp_above_hi     (cmp_above_hi),
      .cmp_below_lo     (cmp_below_lo),
      .pwm_duty         (pwm_duty),
      .pulse_done       (pulse_done),
      .mode_pfm         (mode_pfm),
      .pwm_loop_off     (pwm_loop_off),
      .pfm_trigger      (pfm_trigger),
      .pfm_duty         (pfm_duty),
      .dz_last          (dz_last)
   );

   // Behavioural reference model
   int m_mode, m_run, m_busy, m_trig, m_duty, m_dzrun, m_dzlast;

   always @(posedge clk) begin
      int need;
      if (!rst_n) begin
         m_mode = 0; m_run = 0; m_busy = 0; m_trig = 0;
         m_duty = 0; m_dzrun = 0; m_dzlast = 0;
      end else begin
         need = (cfg_entry_cycles == 0) ? 20 : int'(cfg_entry_cycles);
         m_trig = 0;
         if (!cfg_mode_en) begin
            m_mode = 0; m_run = 0; m_busy = 0; m_dzrun = 0;
         end else if (m_mode == 0) begin
            if (cyc_strobe) begin
               if (int'(i_sample) < int'(cfg_i_thresh)) begin
                  m_run++;
                  if (m_run >= need) begin
                     m_mode = 1; m_run = 0; m_duty = int'(pwm_duty);
                     m_busy = 0; m_dzrun = 0;
                  end
               end else begin
                  m_run = 0;
               end
            end
         end else if (cmp_above_hi || cmp_below_lo) begin
            m_mode = 0; m_run = 0; m_busy = 0; m_dzrun = 0;
         end else if (m_busy != 0) begin
            if (pulse_done) begin
               m_busy = 0; m_dzrun = 0;
            end
         end else if (cmp_below_ref) begin
            m_trig = 1; m_busy = 1; m_dzlast = m_dzrun; m_dzrun = 0;
         end else if (m_dzrun < DZ_MAX) begin
            m_dzrun++;
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("[TB] FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         chk("R1", "model mode_pfm", int'(mode_pfm), m_mode);
         chk("R4", "model pwm_loop_off", int'(pwm_loop_off), m_mode);
         chk("R5", "model pfm_trigger", int'(pfm_trigger), m_trig);
         chk("R9", "model pfm_duty", int'(pfm_duty), m_duty);
         chk("R10", "model dz_last", int'(dz_last), m_dzlast);
      end
   end

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic strobe_once(input int cur);
      cyc_strobe = 1'b1;
      i_sample   = IW'(cur);
      tick();
      cyc_strobe = 1'b0;
      tick();
   endtask

   task automatic feed_low(input int n);
      for (int k = 0; k < n; k++) strobe_once(40);
   endtask

   task automatic finish_run();
      done_flag = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("[TB] FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int trig_seen;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11", "reset mode_pfm", int'(mode_pfm), 0);
      chk("R11", "reset pwm_loop_off", int'(pwm_loop_off), 0);
      chk("R11", "reset pfm_trigger", int'(pfm_trigger), 0);
      chk("R11", "reset pfm_duty", int'(pfm_duty), 0);
      chk("R11", "reset dz_last", int'(dz_last), 0);
      rst_n = 1'b1;
      cfg_mode_en = 1'b1;
      cfg_i_thresh = 10'd100;
      cfg_entry_cycles = 8'd5;
      pwm_duty = 12'h3A5;
      tick();

      // R1: exact entry after five low strobes
      feed_low(4);
      chk("R1", "no entry after 4 low strobes", int'(mode_pfm), 0);
      strobe_once(40);
      chk("R1", "entry after 5th low strobe", int'(mode_pfm), 1);
      chk("R4", "loop off in PFM", int'(pwm_loop_off), 1);
      pwm_duty = 12'h111;
      tick();
      chk("R9", "duty frozen at entry value", int'(pfm_duty), 12'h3A5);

      // R5: first trigger
      cmp_below_ref = 1'b1;
      tick();
      chk("R5", "trigger after below_ref", int'(pfm_trigger), 1);

      // R6: held request gives no extra trigger while busy
      trig_seen = 0;
      for (int k = 0; k < 6; k++) begin
         tick();
         trig_seen += int'(pfm_trigger);
      end
      chk("R6", "no trigger while pulse outstanding", trig_seen, 0);
      pulse_done = 1'b1;
      tick();
      pulse_done = 1'b0;
      trig_seen = 0;
      for (int k = 0; k < 4; k++) begin
         tick();
         trig_seen += int'(pfm_trigger);
      end
      chk("R6", "exactly one trigger after completion", trig_seen, 1);

      // R10: dead zone of 7 idle edges
      cmp_below_ref = 1'b0;
      pulse_done = 1'b1;
      tick();
      pulse_done = 1'b0;
      repeat (7) tick();
      cmp_below_ref = 1'b1;
      tick();
      cmp_below_ref = 1'b0;
      chk("R10", "dead zone length", int'(dz_last), 7);
      pulse_done = 1'b1;
      tick();
      pulse_done = 1'b0;

      // R7: exit on upper window, no trigger that edge
      cmp_above_hi = 1'b1;
      cmp_below_ref = 1'b1;
      tick();
      cmp_above_hi = 1'b0;
      cmp_below_ref = 1'b0;
      chk("R7", "exit on above_hi", int'(mode_pfm), 0);
      chk("R7", "no trigger on exit edge", int'(pfm_trigger), 0);

      // R3: sample equal to threshold restarts the run
      feed_low(3);
      strobe_once(100);
      feed_low(4);
      chk("R3", "run restarted by sample at threshold", int'(mode_pfm), 0);
      strobe_once(40);
      chk("R3", "entry after fresh run of 5", int'(mode_pfm), 1);

      // R7: exit on lower window
      cmp_below_lo = 1'b1;
      tick();
      cmp_below_lo = 1'b0;
      chk("R7", "exit on below_lo", int'(mode_pfm), 0);

      // R2: zero selects 20
      cfg_entry_cycles = 8'd0;
      feed_low(19);
      chk("R2", "no entry after 19 with default", int'(mode_pfm), 0);
      feed_low(1);
      chk("R2", "entry after 20 with default", int'(mode_pfm), 1);

      // R8: disable forces PWM
      cfg_mode_en = 1'b0;
      tick();
      chk("R8", "disable forces PWM", int'(mode_pfm), 0);
      chk("R8", "loop back on when disabled", int'(pwm_loop_off), 0);
      feed_low(25);
      chk("R8", "strobes ignored while disabled", int'(mode_pfm), 0);
      cfg_mode_en = 1'b1;
      feed_low(10);
      cfg_mode_en = 1'b0;
      tick();
      cfg_mode_en = 1'b1;
      feed_low(19);
      chk("R8", "run cleared by disable", int'(mode_pfm), 0);
      feed_low(1);
      chk("R8", "entry after full run following disable", int'(mode_pfm), 1);

      // R10: saturation of the dead-zone count
      repeat (300) tick();
      cmp_below_ref = 1'b1;
      tick();
      cmp_below_ref = 1'b0;
      chk("R10", "dead zone saturates", int'(dz_last), DZ_MAX);
      chk("R5", "trigger after long idle", int'(pfm_trigger), 1);
      tick();

      finish_run();
   end
endmodule